// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small processor core and decides, once per instruction, whether an interrupt is taken and which one. It watches five request inputs: one non-maskable trap, three restart requests that can each be masked, and one general request. It holds the three mask bits and a global interrupt enable. When the core raises its sample strobe (in the next-to-last clock of an instruction, or on any cycle while halted or while the bus is held), the controller picks the highest-priority eligible request and, one clock later, reports the decision for exactly one cycle.

A trap or restart request is answered with a fixed internal restart address, so the core needs no external opcode. A general request asks the core to run an external acknowledge cycle and to hold the program counter, so that an outside device can insert its own opcode. Every accepted interrupt also raises a wake-up pulse that ends halt or power-down. Accepting any maskable request clears the global enable. Software must set it again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all outputs are low, the global enable is clear and all three restart masks are set. Maskable requests are therefore not taken until software sets the enable and clears the masks.
- R2: Fixed priority, highest first: trap, restart-7.5, restart-6.5, restart-5.5, general request.
- R3: An accepted trap reports source code 1 with vector 0x0024. It is taken whatever the masks and the global enable hold, and it leaves the global enable unchanged.
- R4: A trap is taken only after a rising edge on `trap_i`, and only while `trap_i` is still high at the sample. A trap pulse that ends before the sample is dropped. Each rising edge is taken at most once.
- R5: A mask write loads `mask_wdata_i[0]`, `[1]` and `[2]` as the masks of restart-5.5, restart-6.5 and restart-7.5. A bit value of 1 blocks that restart.
- R6: A rising edge on `rst75_i` is held pending after the pin falls, including while it is masked. The pending request clears when it is accepted, or when a mask write has `mask_wdata_i[3]` set.
- R7: Restart-6.5 and restart-5.5 are level requests. They are taken only while the pin is high at the sample and are not remembered.
- R8: `ei_i` sets the global enable and `di_i` clears it. If both arrive in the same cycle, `di_i` wins. Accepting any maskable request clears the enable.
- R9: An accepted general request reports source 5, vector 0, and both `inta_req_o` and `pc_inh_o` high. An accepted restart or trap reports its vector with both of those outputs low.
- R10: Results appear in the cycle after the sample strobe and last one cycle. Source codes are 1 trap, 2 restart-7.5, 3 restart-6.5, 4 restart-5.5 and 5 general. `wake_o` pulses with every acceptance, and the source, vector and acknowledge outputs are 0 in any cycle with no acceptance.
- R11: Without a sample strobe no interrupt is taken, however long the requests are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap request |
| rst75_i | input | 1 | Edge-triggered restart-7.5 request |
| rst65_i | input | 1 | Level restart-6.5 request |
| rst55_i | input | 1 | Level restart-5.5 request |
| intr_i | input | 1 | General request needing external acknowledge |
| sample_i | input | 1 | Sample strobe from the core |
| mask_wr_i | input | 1 | Mask write command |
| mask_wdata_i | input | 4 | [2:0] masks for 7.5/6.5/5.5 (bit 2 to bit 0), [3] clears pending 7.5 |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| take_o | output | 1 | Interrupt accepted (one-cycle pulse) |
| src_o | output | 3 | Accepted source code |
| vector_o | output | 16 | Restart address, 0 for the general request |
| inta_req_o | output | 1 | Request an external acknowledge cycle |
| pc_inh_o | output | 1 | Inhibit program counter increment |
| wake_o | output | 1 | Leave halt or power-down |

## Verification
The bench builds the controller with its default 16-bit vector width and the four default restart addresses. Each decision can then be checked against fixed numbers that are known independently of the design. With these values the bench reaches the corner cases that depend on timing: a trap pulse that ends before the sample, a second sample on one trap edge, and a masked restart-7.5 edge that survives until it is unmasked. It also reaches a mask write that clears the pending edge, enable and disable arriving together, and long runs with requests held but no strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_RST = 3;
  localparam int NUM_SRC = NUM_RST + 2;
  localparam int SRC_W   = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_INTR = 3'd5
  } src_e;
endpackage

// File: rtl/irq_edge_cap.sv
// Rising-edge capture. HOLD_LEVEL=1 drops the pending flag as soon as the pin
// falls (trap); HOLD_LEVEL=0 keeps it until cleared (restart-7.5).
module irq_edge_cap #(
  parameter bit HOLD_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q;
  logic pend_d, rise;

  assign rise = pin_i & ~prev_q;

  generate
    if (HOLD_LEVEL) begin : g_level
      always_comb pend_d = rise | (pend_q & pin_i & ~clr_i);
    end else begin : g_latch
      always_comb pend_d = rise | (pend_q & ~clr_i);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              auto_clr_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              ie_o
);
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              ie_q, ie_d;

  always_comb begin
    mask_d = mask_q;
    if (mask_wr_i) mask_d = mask_wdata_i;
    ie_d = ie_q;
    if (ei_i) ie_d = 1'b1;
    if (di_i || auto_clr_i) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ie_q   <= ie_d;
    end
  end

  assign mask_o = mask_q;
  assign ie_o   = ie_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int                  VEC_W    = 16,
  parameter logic [VEC_W-1:0]    TRAP_VEC = 16'h0024,
  parameter logic [VEC_W-1:0]    R75_VEC  = 16'h003C,
  parameter logic [VEC_W-1:0]    R65_VEC  = 16'h0034,
  parameter logic [VEC_W-1:0]    R55_VEC  = 16'h002C
) (
  input  logic               trap_pend_i,
  input  logic               trap_lvl_i,
  input  logic               r75_pend_i,
  input  logic               r65_lvl_i,
  input  logic               r55_lvl_i,
  input  logic               intr_lvl_i,
  input  logic [NUM_RST-1:0] mask_i,     // [2]=7.5 [1]=6.5 [0]=5.5
  input  logic               ie_i,
  output src_e               src_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               inta_o
);
  logic [NUM_SRC-1:0] req;   // index 0 = highest priority

  always_comb begin
    req[0] = trap_pend_i & trap_lvl_i;
    req[1] = r75_pend_i & ~mask_i[2] & ie_i;
    req[2] = r65_lvl_i  & ~mask_i[1] & ie_i;
    req[3] = r55_lvl_i  & ~mask_i[0] & ie_i;
    req[4] = intr_lvl_i & ie_i;
  end

  always_comb begin
    src_o = SRC_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) src_o = src_e'(i + 1);
    end
  end

  always_comb begin
    inta_o = 1'b0;
    case (src_o)
      SRC_TRAP: vec_o = TRAP_VEC;
      SRC_R75:  vec_o = R75_VEC;
      SRC_R65:  vec_o = R65_VEC;
      SRC_R55:  vec_o = R55_VEC;
      SRC_INTR: begin vec_o = '0; inta_o = 1'b1; end
      default:  vec_o = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] TRAP_VEC = 16'h0024,
  parameter logic [VEC_W-1:0] R75_VEC  = 16'h003C,
  parameter logic [VEC_W-1:0] R65_VEC  = 16'h0034,
  parameter logic [VEC_W-1:0] R55_VEC  = 16'h002C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_i,
  input  logic               rst75_i,
  input  logic               rst65_i,
  input  logic               rst55_i,
  input  logic               intr_i,
  input  logic               sample_i,
  input  logic               mask_wr_i,
  input  logic [NUM_RST:0]   mask_wdata_i,
  input  logic               ei_i,
  input  logic               di_i,
  output logic               take_o,
  output logic [SRC_W-1:0]   src_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               inta_req_o,
  output logic               pc_inh_o,
  output logic               wake_o
);
  localparam int CLR75_BIT = NUM_RST;

  logic               trap_pend, r75_pend;
  logic               trap_clr, r75_clr, auto_clr;
  logic [NUM_RST-1:0] mask_w;
  logic               ie_w;
  src_e               win_src;
  logic [VEC_W-1:0]   win_vec;
  logic               win_inta;
  logic               win_maskable;

  logic               take_q, take_d;
  src_e               src_q, src_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               inta_q, inta_d;

  assign win_maskable = (win_src != SRC_NONE) && (win_src != SRC_TRAP);
  assign trap_clr     = sample_i && (win_src == SRC_TRAP);
  assign r75_clr      = (sample_i && (win_src == SRC_R75)) ||
                        (mask_wr_i && mask_wdata_i[CLR75_BIT]);
  assign auto_clr     = sample_i && win_maskable;

  irq_edge_cap #(.HOLD_LEVEL(1'b1)) u_trap_cap (
    .clk(clk), .rst_n(rst_n), .pin_i(trap_i), .clr_i(trap_clr), .pend_o(trap_pend)
  );

  irq_edge_cap #(.HOLD_LEVEL(1'b0)) u_r75_cap (
    .clk(clk), .rst_n(rst_n), .pin_i(rst75_i), .clr_i(r75_clr), .pend_o(r75_pend)
  );

  irq_mask_regs #(.MASK_W(NUM_RST)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i[NUM_RST-1:0]),
    .ei_i(ei_i), .di_i(di_i), .auto_clr_i(auto_clr),
    .mask_o(mask_w), .ie_o(ie_w)
  );

  irq_arbiter #(
    .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC), .R75_VEC(R75_VEC),
    .R65_VEC(R65_VEC), .R55_VEC(R55_VEC)
  ) u_arb (
    .trap_pend_i(trap_pend), .trap_lvl_i(trap_i), .r75_pend_i(r75_pend),
    .r65_lvl_i(rst65_i), .r55_lvl_i(rst55_i), .intr_lvl_i(intr_i),
    .mask_i(mask_w), .ie_i(ie_w),
    .src_o(win_src), .vec_o(win_vec), .inta_o(win_inta)
  );

  always_comb begin
    take_d = 1'b0;
    src_d  = SRC_NONE;
    vec_d  = '0;
    inta_d = 1'b0;
    if (sample_i) begin
      take_d = (win_src != SRC_NONE);
      src_d  = win_src;
      vec_d  = win_vec;
      inta_d = win_inta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      src_q  <= SRC_NONE;
      vec_q  <= '0;
      inta_q <= 1'b0;
    end else begin
      take_q <= take_d;
      src_q  <= src_d;
      vec_q  <= vec_d;
      inta_q <= inta_d;
    end
  end

  assign take_o     = take_q;
  assign src_o      = src_q;
  assign vector_o   = vec_q;
  assign inta_req_o = inta_q;
  assign pc_inh_o   = inta_q;
  assign wake_o     = take_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int               VEC_W    = 16,
  parameter logic [VEC_W-1:0] TRAP_VEC = 16'h0024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_i,
  input logic             di_i,
  input logic             take_o,
  input logic [2:0]       src_o,
  input logic [VEC_W-1:0] vector_o,
  input logic             inta_req_o,
  input logic             pc_inh_o,
  input logic             ie
);
  // R10
  take_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(sample_i));

  // R10
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (src_o == 3'd0 && !inta_req_o && !pc_inh_o));

  // R9
  inta_only_general_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta_req_o |-> (src_o == 3'd5 && pc_inh_o && vector_o == '0));

  // R3
  trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o == 3'd1) |-> (vector_o == TRAP_VEC && !inta_req_o));

  // R8
  auto_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && src_o != 3'd1) |-> !ie);

  // R8
  disable_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(di_i) |-> !ie);
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .di_i(di_i),
  .take_o(take_o), .src_o(src_o), .vector_o(vector_o),
  .inta_req_o(inta_req_o), .pc_inh_o(pc_inh_o), .ie(ie_w)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trap_i, rst75_i, rst65_i, rst55_i, intr_i;
  logic        sample_i, mask_wr_i, ei_i, di_i;
  logic [3:0]  mask_wdata_i;
  logic        take_o, inta_req_o, pc_inh_o, wake_o;
  logic [2:0]  src_o;
  logic [15:0] vector_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit          take;
    logic [2:0]  src;
    logic [15:0] vec;
    bit          inta;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst75_i(rst75_i),
    .rst65_i(rst65_i), .rst55_i(rst55_i), .intr_i(intr_i),
    .sample_i(sample_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .ei_i(ei_i), .di_i(di_i), .take_o(take_o), .src_o(src_o),
    .vector_o(vector_o), .inta_req_o(inta_req_o), .pc_inh_o(pc_inh_o),
    .wake_o(wake_o)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmd_ei();
    @(negedge clk); ei_i = 1'b1; @(negedge clk); ei_i = 1'b0;
  endtask

  task automatic cmd_mask(input logic [3:0] d);
    @(negedge clk); mask_wr_i = 1'b1; mask_wdata_i = d;
    @(negedge clk); mask_wr_i = 1'b0;
  endtask

  task automatic pulse75();
    @(negedge clk); rst75_i = 1'b1; @(negedge clk); rst75_i = 1'b0;
  endtask

  // driver: push the expectation, then strobe for one cycle
  task automatic strobe(input bit t, input logic [2:0] s, input logic [15:0] v,
                        input bit a, input string tag);
    exp_t e;
    e.take = t; e.src = s; e.vec = v; e.inta = a; e.tag = tag;
    sb.push_back(e);
    @(negedge clk); sample_i = 1'b1;
    @(negedge clk); sample_i = 1'b0;
  endtask

  // monitor: compare against the scoreboard one cycle after each strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && !done) begin
        if (sample_i) begin
          exp_t e;
          @(negedge clk);
          e = sb.pop_front();
          checks++;
          if (take_o !== e.take || src_o !== e.src || vector_o !== e.vec ||
              inta_req_o !== e.inta || pc_inh_o !== e.inta || wake_o !== e.take) begin
            errors++;
            $display("FAIL %s: take=%0b src=%0d vec=%h inta=%0b inh=%0b wake=%0b exp take=%0b src=%0d vec=%h inta=%0b",
                     e.tag, take_o, src_o, vector_o, inta_req_o, pc_inh_o, wake_o,
                     e.take, e.src, e.vec, e.inta);
          end
        end else begin
          @(negedge clk);
          checks++;
          if (take_o !== 1'b0 || wake_o !== 1'b0) begin
            errors++;
            $display("FAIL R11: take=%0b wake=%0b without strobe, exp 0", take_o, wake_o);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; trap_i = 0; rst75_i = 0; rst65_i = 0; rst55_i = 0; intr_i = 0;
    sample_i = 0; mask_wr_i = 0; mask_wdata_i = '0; ei_i = 0; di_i = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state of the outputs
    checks++;
    if (take_o !== 0 || src_o !== 0 || vector_o !== 0 || inta_req_o !== 0 ||
        pc_inh_o !== 0 || wake_o !== 0) begin
      errors++;
      $display("FAIL R1: outputs after reset take=%0b src=%0d vec=%h, exp all 0",
               take_o, src_o, vector_o);
    end
    // R1: enable clear and masks set
    rst55_i = 1; intr_i = 1;
    strobe(0, 3'd0, 16'h0000, 0, "R1");
    // R3: trap taken though enable is clear and masks set
    trap_i = 1;
    strobe(1, 3'd1, 16'h0024, 0, "R3");
    // R4: once per edge
    strobe(0, 3'd0, 16'h0000, 0, "R4");
    trap_i = 0; cyc(1);
    // R4: pulse gone before the sample
    trap_i = 1; cyc(1); trap_i = 0;
    strobe(0, 3'd0, 16'h0000, 0, "R4");
    // R2: 5.5 over general request
    cmd_ei(); cmd_mask(4'b0000);
    strobe(1, 3'd4, 16'h002C, 0, "R2");
    // R8: auto-disabled
    strobe(0, 3'd0, 16'h0000, 0, "R8");
    // R9: general request
    cmd_ei(); rst55_i = 0;
    strobe(1, 3'd5, 16'h0000, 1, "R9");
    intr_i = 0;
    // R6/R2: latched 7.5 edge beats 6.5 level
    pulse75(); cmd_ei(); rst65_i = 1;
    strobe(1, 3'd2, 16'h003C, 0, "R6");
    cmd_ei();
    strobe(1, 3'd3, 16'h0034, 0, "R7");
    // R7: level not remembered
    rst65_i = 0; cmd_ei();
    strobe(0, 3'd0, 16'h0000, 0, "R7");
    // R5: masked 7.5 edge is blocked, then taken after unmask (R6)
    cmd_mask(4'b0100); pulse75();
    strobe(0, 3'd0, 16'h0000, 0, "R5");
    cmd_mask(4'b0000);
    strobe(1, 3'd2, 16'h003C, 0, "R6");
    // R6: mask write bit 3 clears the pending edge
    pulse75(); cmd_mask(4'b1000); cmd_ei();
    strobe(0, 3'd0, 16'h0000, 0, "R6");
    // R5: 6.5 masked, 5.5 taken
    cmd_mask(4'b0010); rst65_i = 1; rst55_i = 1;
    strobe(1, 3'd4, 16'h002C, 0, "R5");
    rst65_i = 0; rst55_i = 0; cmd_mask(4'b0000);
    // R8: disable wins over enable
    intr_i = 1;
    @(negedge clk); ei_i = 1; di_i = 1; @(negedge clk); ei_i = 0; di_i = 0;
    strobe(0, 3'd0, 16'h0000, 0, "R8");
    cmd_ei();
    strobe(1, 3'd5, 16'h0000, 1, "R8");
    // R2/R3: trap over general, enable untouched by trap
    cmd_ei(); trap_i = 1;
    strobe(1, 3'd1, 16'h0024, 0, "R2");
    trap_i = 0;
    strobe(1, 3'd5, 16'h0000, 1, "R3");
    // R11: held requests, no strobe
    cmd_ei(); cyc(6);
    strobe(1, 3'd5, 16'h0000, 1, "R10");
    intr_i = 0;
    cyc(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule